// File: doc/BRIEF.md
# Conversion Output Sequencer with Strobe Window

This block drives the steps that follow a finished time measurement. When the measuring stage reports a result together with its count, the sequencer waits a programmable delay and then opens a conversion-ready window. In internal mode the output pulse follows at once. In external mode the pulse is produced only if a strobe arrives while the window is open. If no strobe arrives, the window closes and the cycle ends with no output.

A classifier checks whether the stored count lies inside a window. The window is given by a lower bound and a width, both in count units. The classifier raises its own pulse during the output slot, and it can optionally veto the output pulse. Every cycle ends with a clear period whose length depends on the range multiplier. A one-cycle acknowledge at the end of that period lets the upstream acceptance logic re-arm. An inhibit input may abort the cycle at any point and holds the block in clear for as long as it stays high.

All durations are clock-cycle counts derived from the `CLK_MHZ` parameter. The figures below assume the default of 100 MHz.

Top module: `conv_out_seq`

## Requirements
- R1: A non-overrange `done_i` sampled in idle starts a delay of D cycles. D is `dly_i` clamped to the range 15 to 1050 (150 ns to 10.5 µs). `rdy_o` rises D cycles after the edge that sampled `done_i`, and `valid_o` is a one-cycle pulse in the first cycle of `rdy_o`.
- R2: In external mode with no strobe inside the window, `rdy_o` stays high for W cycles and the block then enters clear with no output. W is `rdy_set_i` clamped to 1..20, multiplied by 100, or by 1000 when `rdy_long_i` is 1.
- R3: In internal mode (`ext_mode_i`=0), `rdy_o` is high for one cycle and the output slot begins in the next cycle.
- R4: In external mode, a strobe sampled in any window cycle, including the last, starts the output slot in the next cycle and closes the window. A strobe at any other time is ignored.
- R5: The output slot lasts 50, 100 or 250 cycles (0.5, 1.0 or 2.5 µs) for `owid_i` = 0, 1 or 2/3 respectively.
- R6: `sca_o` is high for the whole output slot exactly when `win_lo_i` <= count <= `win_lo_i` + `win_w_i`. The sum is formed without truncation.
- R7: With `gate_en_i`=1, a count outside the window leaves `out_o` low for the whole slot. `valid_o` and all timing are unchanged. With `gate_en_i`=0, `out_o` is high for the whole slot.
- R8: The clear period lasts 100 cycles for `mult_i` 0 or 1, 500 cycles for 2, and 4000 cycles for 3 to 7. It follows an output slot, an expired window, an overrange or an inhibit.
- R9: `done_i` with `ovr_i`=1 sampled in idle goes straight to clear, with no `valid_o`, `rdy_o`, `out_o` or `sca_o`.
- R10: `inhibit_i` sampled high in any state moves the block to clear in the next cycle and ends any output at once. Clear then ends at the later of the full clear time and the release of `inhibit_i`.
- R11: `ack_o` is high for exactly one cycle, the last cycle of clear, and the block is idle after it. `done_i` is ignored whenever the block is not idle.
- R12: While `rst_n` is low, and in the first cycle after its release, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_i | input | 1 | One-cycle pulse: a measurement has finished |
| ovr_i | input | 1 | Qualifies `done_i`: the measurement overranged |
| meas_i | input | CNT_W | Measured count, captured with `done_i` |
| ext_mode_i | input | 1 | 0 = output after delay, 1 = output needs a strobe |
| strobe_i | input | 1 | External strobe |
| inhibit_i | input | 1 | Abort and hold in clear while high |
| dly_i | input | DLY_W | Delay setting in cycles (clamped) |
| rdy_set_i | input | 5 | Window width setting, 1..20 units |
| rdy_long_i | input | 1 | Window unit: 0 = 1 µs, 1 = 10 µs |
| owid_i | input | 2 | Output slot width select |
| mult_i | input | 3 | Range multiplier code, sets clear length |
| gate_en_i | input | 1 | Let the classifier veto the output |
| win_lo_i | input | CNT_W | Classifier lower bound |
| win_w_i | input | CNT_W | Classifier window width |
| out_o | output | 1 | Output pulse |
| sca_o | output | 1 | Classifier pulse |
| rdy_o | output | 1 | Conversion-ready window |
| valid_o | output | 1 | Valid-conversion pulse |
| ack_o | output | 1 | Cycle-complete acknowledge |

## Verification
Conversions run in internal mode and in external mode. In external mode the strobe falls in the first, a middle and the last window cycle, or is absent, which separates strobe acceptance from window expiry and shows where the window truly ends. Counts are placed on, just inside and just outside both classifier edges, including a bound-plus-width sum past full scale, to expose an off-by-one or a truncated sum, with gating both on and off. Inhibit is released both before and after the clear time, and is applied in idle, in the delay and in the middle of an output slot, to tell apart "later of the two" from either single source.

// File: rtl/conv_out_seq.sv
module conv_out_seq #(
  parameter int CNT_W   = 12,
  parameter int DLY_W   = 11,
  parameter int CLK_MHZ = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_i,
  input  logic             ovr_i,
  input  logic [CNT_W-1:0] meas_i,
  input  logic             ext_mode_i,
  input  logic             strobe_i,
  input  logic             inhibit_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic [4:0]       rdy_set_i,
  input  logic             rdy_long_i,
  input  logic [1:0]       owid_i,
  input  logic [2:0]       mult_i,
  input  logic             gate_en_i,
  input  logic [CNT_W-1:0] win_lo_i,
  input  logic [CNT_W-1:0] win_w_i,
  output logic             out_o,
  output logic             sca_o,
  output logic             rdy_o,
  output logic             valid_o,
  output logic             ack_o
);
  localparam int MIN_DLY = CLK_MHZ * 150 / 1000;
  localparam int MAX_DLY = CLK_MHZ * 21 / 2;
  localparam int CW      = $clog2(200 * CLK_MHZ + 1);

  typedef enum logic [2:0] {S_IDLE, S_DLY, S_WIN, S_OUT, S_RST} st_t;

  st_t              state;
  logic [CW-1:0]    cnt, dly_len, win_len, pw_len, rst_len;
  logic [CNT_W-1:0] meas_q;
  logic [4:0]       rdy_eff;
  logic             hit, cnt_z;

  assign cnt_z = (cnt == '0);

  always_comb begin
    if (int'(dly_i) < MIN_DLY)      dly_len = CW'(MIN_DLY);
    else if (int'(dly_i) > MAX_DLY) dly_len = CW'(MAX_DLY);
    else                            dly_len = CW'(dly_i);
  end

  always_comb begin
    if (rdy_set_i == 5'd0)       rdy_eff = 5'd1;
    else if (rdy_set_i > 5'd20)  rdy_eff = 5'd20;
    else                         rdy_eff = rdy_set_i;
  end

  assign win_len = CW'(int'(rdy_eff) * (rdy_long_i ? 10 * CLK_MHZ : CLK_MHZ));

  always_comb begin
    case (owid_i)
      2'd0:    pw_len = CW'(CLK_MHZ / 2);
      2'd1:    pw_len = CW'(CLK_MHZ);
      default: pw_len = CW'(CLK_MHZ * 5 / 2);
    endcase
  end

  always_comb begin
    case (mult_i)
      3'd0, 3'd1: rst_len = CW'(CLK_MHZ);
      3'd2:       rst_len = CW'(5 * CLK_MHZ);
      default:    rst_len = CW'(40 * CLK_MHZ);
    endcase
  end

  assign hit = (meas_q >= win_lo_i) &&
               ({1'b0, meas_q} <= ({1'b0, win_lo_i} + {1'b0, win_w_i}));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      meas_q  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (inhibit_i && state != S_RST) begin
        state <= S_RST;
        cnt   <= rst_len - 1'b1;
      end else begin
        case (state)
          S_IDLE: if (done_i) begin
            meas_q <= meas_i;
            if (ovr_i) begin
              state <= S_RST;
              cnt   <= rst_len - 1'b1;
            end else begin
              state <= S_DLY;
              cnt   <= dly_len - 1'b1;
            end
          end
          S_DLY: if (cnt_z) begin
            state   <= S_WIN;
            cnt     <= win_len - 1'b1;
            valid_o <= 1'b1;
          end else cnt <= cnt - 1'b1;
          S_WIN: if (!ext_mode_i || strobe_i) begin
            state <= S_OUT;
            cnt   <= pw_len - 1'b1;
          end else if (cnt_z) begin
            state <= S_RST;
            cnt   <= rst_len - 1'b1;
          end else cnt <= cnt - 1'b1;
          S_OUT: if (cnt_z) begin
            state <= S_RST;
            cnt   <= rst_len - 1'b1;
          end else cnt <= cnt - 1'b1;
          S_RST: if (!cnt_z) cnt <= cnt - 1'b1;
                 else if (!inhibit_i) state <= S_IDLE;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign rdy_o = (state == S_WIN);
  assign sca_o = (state == S_OUT) && hit;
  assign out_o = (state == S_OUT) && (!gate_en_i || hit);
  assign ack_o = (state == S_RST) && cnt_z && !inhibit_i;

  assert_valid_in_rdy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> rdy_o);
  assert_valid_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  assert_int_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_o && !ext_mode_i && !inhibit_i) |=> (state == S_OUT));
  assert_out_from_win_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state == S_OUT) |-> $past(state == S_WIN));
  assert_sca_with_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sca_o && !gate_en_i) |-> out_o);
  assert_gate_veto_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en_i && !sca_o) |-> !out_o);
  assert_ovr_to_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && done_i && ovr_i && !inhibit_i) |=> (state == S_RST && !rdy_o));
  assert_inhibit_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit_i |=> !(out_o || rdy_o || valid_o || sca_o));
  assert_inhibit_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RST && inhibit_i) |=> (state == S_RST));
  assert_ack_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> (!ack_o && !rdy_o && !out_o && state == S_IDLE));
endmodule

// File: tb/tb_conv_out_seq.sv
`timescale 1ns/1ps
module tb_conv_out_seq;
  localparam int CNT_W = 12;
  localparam int DLY_W = 11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic done_i = 0, ovr_i = 0, ext_mode_i = 0, strobe_i = 0, inhibit_i = 0;
  logic [CNT_W-1:0] meas_i = '0, win_lo_i = '0, win_w_i = '0;
  logic [DLY_W-1:0] dly_i = '0;
  logic [4:0] rdy_set_i = '0;
  logic rdy_long_i = 0, gate_en_i = 0;
  logic [1:0] owid_i = '0;
  logic [2:0] mult_i = '0;
  logic out_o, sca_o, rdy_o, valid_o, ack_o;

  conv_out_seq #(.CNT_W(CNT_W), .DLY_W(DLY_W), .CLK_MHZ(100)) dut (
    .clk(clk), .rst_n(rst_n), .done_i(done_i), .ovr_i(ovr_i), .meas_i(meas_i),
    .ext_mode_i(ext_mode_i), .strobe_i(strobe_i), .inhibit_i(inhibit_i),
    .dly_i(dly_i), .rdy_set_i(rdy_set_i), .rdy_long_i(rdy_long_i),
    .owid_i(owid_i), .mult_i(mult_i), .gate_en_i(gate_en_i),
    .win_lo_i(win_lo_i), .win_w_i(win_w_i),
    .out_o(out_o), .sca_o(sca_o), .rdy_o(rdy_o), .valid_o(valid_o), .ack_o(ack_o));

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int out_start; int out_len; int sca_len; int rdy_len; int valid_n; int ack_cyc; string rq;
  } exp_t;
  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, expv);
    end
  endtask

  function automatic int f_dly();
    int x = int'(dly_i);
    if (x < 15) return 15;
    if (x > 1050) return 1050;
    return x;
  endfunction
  function automatic int f_win();
    int s = int'(rdy_set_i);
    if (s == 0) s = 1;
    if (s > 20) s = 20;
    return s * (rdy_long_i ? 1000 : 100);
  endfunction
  function automatic int f_pw();
    if (owid_i == 2'd0) return 50;
    if (owid_i == 2'd1) return 100;
    return 250;
  endfunction
  function automatic int f_rst();
    if (mult_i <= 3'd1) return 100;
    if (mult_i == 3'd2) return 500;
    return 4000;
  endfunction
  function automatic bit f_hit(input int m);
    int lo = int'(win_lo_i);
    int w  = int'(win_w_i);
    return (m >= lo) && (m <= lo + w);
  endfunction

  initial begin
    int o_st, o_len, s_len, r_len, v_n;
    exp_t e;
    o_st = -1; o_len = 0; s_len = 0; r_len = 0; v_n = 0;
    forever begin
      @(negedge clk); #1;
      if (!rst_n) continue;
      if (out_o) begin if (o_st < 0) o_st = cyc; o_len++; end
      if (sca_o) s_len++;
      if (rdy_o) r_len++;
      if (valid_o) v_n++;
      if (ack_o) begin
        if (q.size() == 0) chk(0, "R11", "unexpected ack", cyc, -1);
        else begin
          e = q.pop_front();
          chk(o_st == e.out_start, e.rq, "output start", o_st, e.out_start);
          chk(o_len == e.out_len, e.rq, "output length", o_len, e.out_len);
          chk(s_len == e.sca_len, e.rq, "classifier length", s_len, e.sca_len);
          chk(r_len == e.rdy_len, e.rq, "ready length", r_len, e.rdy_len);
          chk(v_n == e.valid_n, e.rq, "valid pulses", v_n, e.valid_n);
          chk(cyc == e.ack_cyc, e.rq, "ack cycle", cyc, e.ack_cyc);
        end
        o_st = -1; o_len = 0; s_len = 0; r_len = 0; v_n = 0;
      end
    end
  end

  task automatic conv(input int meas, input bit ovr, input int s, input bit stray, input string rq);
    int k, d, w, p, r, st, ol;
    bit h;
    exp_t e;
    @(negedge clk);
    meas_i = meas[CNT_W-1:0]; ovr_i = ovr; done_i = 1;
    k = cyc + 1;
    @(negedge clk); done_i = 0; ovr_i = 0;
    d = f_dly(); w = f_win(); p = f_pw(); r = f_rst(); h = f_hit(meas);
    e.rq = rq; e.valid_n = ovr ? 0 : 1;
    if (ovr) begin st = -1; e.rdy_len = 0; e.ack_cyc = k + r - 1; end
    else if (!ext_mode_i) begin st = k + d + 1; e.rdy_len = 1; e.ack_cyc = k + d + p + r; end
    else if (s >= 0) begin st = k + d + s + 1; e.rdy_len = s + 1; e.ack_cyc = k + d + s + p + r; end
    else begin st = -1; e.rdy_len = w; e.ack_cyc = k + d + w + r - 1; end
    ol = (st >= 0 && (!gate_en_i || h)) ? p : 0;
    e.out_len = ol;
    e.out_start = (ol > 0) ? st : -1;
    e.sca_len = (st >= 0 && h) ? p : 0;
    q.push_back(e);
    if (stray) begin
      done_i = 1; ovr_i = 1; strobe_i = 1;
      @(negedge clk); done_i = 0; ovr_i = 0; strobe_i = 0;
    end
    if (ext_mode_i && s >= 0 && !ovr) begin
      while (cyc < k + d + s) @(negedge clk);
      strobe_i = 1;
      @(negedge clk); strobe_i = 0;
    end
    while (cyc < e.ack_cyc + 2) @(negedge clk);
  endtask

  task automatic inh(input bit with_done, input int off, input int hold, input int meas, input string rq);
    int base, i, j, d, p, r, ol, lastc;
    exp_t e;
    @(negedge clk);
    if (with_done) begin
      meas_i = meas[CNT_W-1:0]; done_i = 1; base = cyc + 1;
      @(negedge clk); done_i = 0;
    end else base = cyc;
    d = f_dly(); p = f_pw(); r = f_rst();
    i = base + off; j = i + hold;
    e.rq = rq;
    e.rdy_len = (with_done && i >= base + d) ? 1 : 0;
    e.valid_n = e.rdy_len;
    ol = 0;
    if (with_done && i >= base + d + 1) begin
      lastc = (i < base + d + p) ? i : base + d + p;
      ol = lastc - (base + d + 1) + 1;
    end
    e.out_len = ol;
    e.out_start = (ol > 0) ? base + d + 1 : -1;
    e.sca_len = (ol > 0 && f_hit(meas)) ? ol : 0;
    e.ack_cyc = (j > i + r) ? j : i + r;
    q.push_back(e);
    while (cyc < i) @(negedge clk);
    inhibit_i = 1;
    while (cyc < j) @(negedge clk);
    inhibit_i = 0;
    while (cyc < e.ack_cyc + 2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog: actual %0d expected %0d", cyc, 0);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    dly_i = 11'd20; rdy_set_i = 5'd1; owid_i = 2'd0; mult_i = 3'd0;
    win_lo_i = 12'd100; win_w_i = 12'd50;
    repeat (3) @(negedge clk);
    chk({out_o, sca_o, rdy_o, valid_o, ack_o} == 5'b0, "R12", "outputs in reset",
        int'({out_o, sca_o, rdy_o, valid_o, ack_o}), 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk({out_o, sca_o, rdy_o, valid_o, ack_o} == 5'b0, "R12", "outputs after reset",
        int'({out_o, sca_o, rdy_o, valid_o, ack_o}), 0);

    conv(120, 0, -1, 0, "R3");
    dly_i = 11'd3;    conv(120, 0, -1, 0, "R1");
    dly_i = 11'd2000; conv(120, 0, -1, 0, "R1");
    dly_i = 11'd20;

    owid_i = 2'd1; conv(120, 0, -1, 0, "R5");
    owid_i = 2'd2; conv(120, 0, -1, 0, "R5");
    owid_i = 2'd3; conv(120, 0, -1, 0, "R5");
    owid_i = 2'd0;

    mult_i = 3'd2; conv(120, 0, -1, 0, "R8");
    mult_i = 3'd3; conv(120, 0, -1, 0, "R8");
    mult_i = 3'd6; conv(120, 0, -1, 0, "R8");
    mult_i = 3'd1; conv(120, 0, -1, 0, "R8");
    mult_i = 3'd0;

    ext_mode_i = 1;
    conv(120, 0, 0, 1, "R4");
    conv(120, 0, 37, 0, "R4");
    conv(120, 0, 99, 0, "R4");
    conv(120, 0, -1, 1, "R2");
    rdy_set_i = 5'd0;  conv(120, 0, -1, 0, "R2");
    rdy_set_i = 5'd31; conv(120, 0, -1, 0, "R2");
    rdy_set_i = 5'd1; rdy_long_i = 1; conv(120, 0, -1, 0, "R2");
    rdy_long_i = 0; ext_mode_i = 0;

    conv(100, 0, -1, 0, "R6");
    conv(150, 0, -1, 0, "R6");
    conv(151, 0, -1, 0, "R6");
    conv(99,  0, -1, 0, "R6");
    win_lo_i = 12'd4000; win_w_i = 12'd200;
    conv(4095, 0, -1, 0, "R6");
    win_lo_i = 12'd100; win_w_i = 12'd50;

    gate_en_i = 1;
    conv(200, 0, -1, 0, "R7");
    conv(120, 0, -1, 0, "R7");
    gate_en_i = 0;

    conv(120, 1, -1, 0, "R9");
    mult_i = 3'd2; conv(120, 1, -1, 0, "R9"); mult_i = 3'd0;

    inh(1, 5, 10, 120, "R10");
    inh(1, 5, 300, 120, "R10");
    inh(0, 0, 50, 0, "R10");
    inh(1, 26, 10, 120, "R10");

    conv(120, 0, -1, 1, "R11");
    repeat (5) @(negedge clk);
    chk(q.size() == 0, "R11", "pending expected items", q.size(), 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule